// File: doc/BRIEF.md
# GPIO Interrupt Summary and End-of-Interrupt Gate

The block gathers the per-pin pending flags of a GPIO controller (184 pins by default) into a compact summary vector. Each summary bit covers one group of four consecutive pins, so software can find the pins that need service without scanning every pin. The summary is read through a small register port as two 32-bit words. The port also reaches a master control word whose only active bit is an end-of-interrupt (EOI) strobe.

The block drives one interrupt line toward the system interrupt controller. Once the line rises, it stays high until software writes EOI, whether or not the pending pins have been cleared. After an EOI write the line drops for one cycle. It then rises again if any summary bit is still set, so a condition that arrives during service is not lost.

Top module: `gpio_int_summary`

## Requirements
- R1: Summary bit g is the OR of pending flags of pins 4g, 4g+1, 4g+2 and 4g+3; reading with `reg_sel_i`=0 returns summary bits 31..0 (bit g of the word is group g).
- R2: Reading with `reg_sel_i`=1 returns summary bits 45..32 in word bits 13..0, and word bits 31..14 read as zero.
- R3: Reading any word has no side effect: the interrupt line and later read values are unchanged by reads.
- R4: While the line is low and any summary bit is set at a rising clock edge, `irq_o` is high after that edge. The line never rises without a pending group.
- R5: Once high, `irq_o` stays high, even if every pending flag clears, until an EOI write.
- R6: An EOI write is a write with `reg_sel_i`=2 and `reg_wdata_i` bit 29 set. At the edge that takes it, `irq_o` goes low for at least one cycle.
- R7: If any summary bit is set in the cycle after the EOI write, `irq_o` is high again at the next edge.
- R8: The EOI bit clears itself: a read with `reg_sel_i`=2 returns zero in every bit, and so does a read with `reg_sel_i`=3.
- R9: Writes to the summary words, and writes to the master word with bit 29 clear, do not change the interrupt line.
- R10: During reset `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | 184 | Per-pin pending flags |
| reg_sel_i | input | 2 | Word select: 0 summary low, 1 summary high, 2 master, 3 unused |
| reg_wr_i | input | 1 | Write strobe for the selected word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected word (combinational) |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions assume that `pend_i`, `reg_sel_i`, `reg_wr_i` and `reg_wdata_i` are stable around each rising edge and hold known values after reset. They also treat an EOI write as a one-cycle event. The stimulus changes every input only on the falling edge and holds `reg_wr_i` high for a single cycle for each write. It covers the cases the line-hold assertions depend on: the pending flags clear while the line is held, and flags are still pending when EOI arrives.

// File: rtl/gpio_isum_pkg.sv
package gpio_isum_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_SUM_LO = 2'd0,
    SEL_SUM_HI = 2'd1,
    SEL_MASTER = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_HELD = 1'b1
  } gate_st_e;
endpackage

// File: rtl/isum_group_or.sv
module isum_group_or #(
  parameter int unsigned NUM_PINS = 184,
  parameter int unsigned GRP_SIZE = 4,
  parameter int unsigned NUM_GRP  = (NUM_PINS + GRP_SIZE - 1) / GRP_SIZE
) (
  input  logic [NUM_PINS-1:0] pend_i,
  output logic [NUM_GRP-1:0]  summary_o,
  output logic                any_o
);
  localparam int unsigned PAD_W = NUM_GRP * GRP_SIZE;

  logic [PAD_W-1:0] pend_pad;

  generate
    if (PAD_W > NUM_PINS) begin : g_pad
      assign pend_pad = {{(PAD_W-NUM_PINS){1'b0}}, pend_i};
    end else begin : g_nopad
      assign pend_pad = pend_i;
    end
  endgenerate

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign summary_o[g] = |pend_pad[g*GRP_SIZE +: GRP_SIZE];
  end

  assign any_o = |summary_o;
endmodule

// File: rtl/isum_reg_port.sv
module isum_reg_port
  import gpio_isum_pkg::*;
#(
  parameter int unsigned NUM_GRP = 46,
  parameter int unsigned EOI_POS = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        sel_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_GRP-1:0] summary_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              eoi_o
);
  localparam int unsigned SUM_W  = 2 * DATA_W;
  localparam int unsigned HI_USE = NUM_GRP - DATA_W;

  logic [SUM_W-1:0] sum_pad;
  logic             unused_wdata;

  always_comb begin
    sum_pad = '0;
    sum_pad[NUM_GRP-1:0] = summary_i;
  end

  always_comb begin
    unique case (reg_sel_e'(sel_i))
      SEL_SUM_LO: rdata_o = sum_pad[DATA_W-1:0];
      SEL_SUM_HI: rdata_o = sum_pad[SUM_W-1:DATA_W];
      default:    rdata_o = '0; // EOI self-clears; spare word is empty
    endcase
  end

  assign eoi_o = wr_i && (reg_sel_e'(sel_i) == SEL_MASTER) && wdata_i[EOI_POS];
  assign unused_wdata = ^wdata_i;

  assert_hi_pad_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd1) |-> (rdata_o[DATA_W-1:HI_USE] == '0));

  assert_master_reads_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i[1] == 1'b1) |-> (rdata_o == '0));
endmodule

// File: rtl/isum_irq_gate.sv
module isum_irq_gate
  import gpio_isum_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_pend_i,
  input  logic eoi_i,
  output logic irq_o
);
  gate_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GATE_IDLE: if (any_pend_i) st_d = GATE_HELD;
      GATE_HELD: if (eoi_i)      st_d = GATE_IDLE;
      default:                   st_d = GATE_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= GATE_IDLE;
    else         st_q <= st_d;
  end

  assign irq_o = (st_q == GATE_HELD);

  assert_rise_needs_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(any_pend_i));

  assert_idle_raise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && any_pend_i) |=> irq_o);

  assert_hold_until_eoi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !eoi_i) |=> irq_o);

  assert_release_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && eoi_i) |=> !irq_o);
endmodule

// File: rtl/gpio_int_summary.sv
module gpio_int_summary
  import gpio_isum_pkg::*;
#(
  parameter int unsigned NUM_PINS = 184,
  parameter int unsigned GRP_SIZE = 4,
  parameter int unsigned EOI_POS  = 29
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pend_i,
  input  logic [1:0]          reg_sel_i,
  input  logic                reg_wr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_o
);
  localparam int unsigned NUM_GRP = (NUM_PINS + GRP_SIZE - 1) / GRP_SIZE;

  logic [NUM_GRP-1:0] summary;
  logic               any_pend;
  logic               eoi;

  isum_group_or #(
    .NUM_PINS (NUM_PINS),
    .GRP_SIZE (GRP_SIZE),
    .NUM_GRP  (NUM_GRP)
  ) u_grp (
    .pend_i    (pend_i),
    .summary_o (summary),
    .any_o     (any_pend)
  );

  isum_reg_port #(
    .NUM_GRP (NUM_GRP),
    .EOI_POS (EOI_POS)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (reg_sel_i),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .summary_i (summary),
    .rdata_o   (reg_rdata_o),
    .eoi_o     (eoi)
  );

  isum_irq_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .any_pend_i (any_pend),
    .eoi_i      (eoi),
    .irq_o      (irq_o)
  );

  assert_read_no_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !reg_wr_i) |=> irq_o);
endmodule

// File: tb/sim_gpio_int_summary.sv
module sim_gpio_int_summary;
  localparam int CLK_P = 10;
  localparam int NP    = 184;
  localparam int NG    = 46;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pend = '0;
  logic [1:0]    sel = 2'd0;
  logic          wr = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit m_irq = 1'b0;

  string       tag_q[$];
  logic [31:0] rd_q[$];
  bit          irq_q[$];

  always #(CLK_P/2) clk = ~clk;

  gpio_int_summary u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pend_i      (pend),
    .reg_sel_i   (sel),
    .reg_wr_i    (wr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  function automatic logic [31:0] exp_word(input logic [NP-1:0] p, input logic [1:0] s);
    logic [63:0] v;
    v = '0;
    for (int g = 0; g < NG; g++) begin
      v[g] = p[4*g] | p[4*g+1] | p[4*g+2] | p[4*g+3];
    end
    case (s)
      2'd0:    return v[31:0];
      2'd1:    return v[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic step(input logic [NP-1:0] p, input logic [1:0] s, input logic w,
                      input logic [31:0] d, input string tag);
    @(negedge clk);
    pend = p; sel = s; wr = w; wdata = d;
    if (m_irq) begin
      if (w && s == 2'd2 && d[29]) m_irq = 1'b0;
    end else if (|p) begin
      m_irq = 1'b1;
    end
    tag_q.push_back(tag);
    rd_q.push_back(exp_word(p, s));
    irq_q.push_back(m_irq);
  endtask

  function automatic logic [NP-1:0] pin(input int k);
    logic [NP-1:0] v;
    v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

  // monitor: one expected item per cycle, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (tag_q.size() > 0) begin
        string t;
        logic [31:0] er;
        bit ei;
        t = tag_q.pop_front();
        er = rd_q.pop_front();
        ei = irq_q.pop_front();
        n_cmp++;
        if (rdata !== er) begin
          n_bad++;
          $display("FAIL %s rdata actual=%h expected=%h", t, rdata, er);
        end
        n_cmp++;
        if (irq !== ei) begin
          n_bad++;
          $display("FAIL %s irq actual=%b expected=%b", t, irq, ei);
        end
      end
    end
  end

  initial begin
    #(CLK_P*20000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [NP-1:0] all1;
    all1 = '1;
    #(CLK_P*2 + 2);
    n_cmp++;
    if (irq !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 irq actual=%b expected=0", irq);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R2 idle reads
    step('0, 2'd0, 1'b0, 32'h0, "R1 idle lo");
    step('0, 2'd1, 1'b0, 32'h0, "R2 idle hi");
    // R1 pin 5 -> group 1, R4 line rises
    step(pin(5), 2'd0, 1'b0, 32'h0, "R4 R1 pin5");
    step(pin(127), 2'd0, 1'b0, 32'h0, "R1 pin127");
    step(pin(128), 2'd1, 1'b0, 32'h0, "R2 pin128");
    step(pin(183), 2'd1, 1'b0, 32'h0, "R2 pin183");
    step(all1, 2'd0, 1'b0, 32'h0, "R1 all lo");
    step(all1, 2'd1, 1'b0, 32'h0, "R2 all hi");
    // R3 repeated reads
    for (int i = 0; i < 3; i++) step(pin(66), 2'd0, 1'b0, 32'h0, "R3 reread");
    // R5 flags clear, line held
    step('0, 2'd0, 1'b0, 32'h0, "R5 clear");
    step('0, 2'd3, 1'b0, 32'h0, "R5 R8 spare");
    // R9 ignored writes
    step('0, 2'd0, 1'b1, 32'hFFFF_FFFF, "R9 wr lo");
    step('0, 2'd1, 1'b1, 32'hFFFF_FFFF, "R9 wr hi");
    step('0, 2'd2, 1'b1, 32'hDFFF_FFFF, "R9 master no eoi");
    // R6 EOI release, nothing pending
    step('0, 2'd2, 1'b1, 32'h2000_0000, "R6 eoi");
    step('0, 2'd2, 1'b0, 32'h0, "R8 master read");
    step('0, 2'd0, 1'b0, 32'h0, "R6 stays low");
    // R7 EOI while pending
    step(pin(90), 2'd1, 1'b0, 32'h0, "R4 re-arm");
    step(pin(90), 2'd2, 1'b1, 32'h2000_0000, "R6 eoi pending");
    step(pin(90), 2'd0, 1'b0, 32'h0, "R7 reassert");
    step(pin(90), 2'd0, 1'b0, 32'h0, "R5 held");
    // R4 no rise without pend after release
    step('0, 2'd2, 1'b1, 32'h2000_0000, "R6 eoi2");
    step('0, 2'd0, 1'b0, 32'h0, "R4 quiet");
    step('0, 2'd0, 1'b0, 32'h0, "R4 quiet2");
    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule